// File: doc/BRIEF.md
# Last-Branch Record Ring Buffer

This block keeps a history of recently retired control-flow transfers. Each transfer is offered on a valid/ready stream with its source address, its target address, a 3-bit class code, the privilege levels of source and target, and a misprediction flag. Whatever passes the capture filter is written into a circular store of `DEPTH` entries. A top-of-stack pointer always names the newest entry. A 10-bit select register picks what is captured. Bits 0 to 8 suppress kinds of transfer. Bit 9 switches the store into call-stack mode: calls push, near returns pop, and every other class leaves the store alone.

A performance-interrupt pulse freezes recording so that the history stays intact for the handler. This happens only outside call-stack mode. While frozen, the pointer and the entries hold until software clears the freeze. A global enable gates all recording. Software reads entries by position back from the newest, with a response one cycle later. A write port lets software restore an entry at a physical index and set the pointer.

The branch stream obeys these back-pressure rules. `br_ready` drops only in a cycle where software writes an entry or the pointer. A source that sees `br_ready` low holds its transfer and offers it again. A transfer accepted while the block is disabled, frozen or filtered out is consumed and not recorded.

Top module: `lbr_ring`

## Requirements
- R1: After reset the pointer is 0, the block is not frozen, the select register is 0, and every entry reads as from=0, to=0, info=0.
- R2: Outside call-stack mode, a captured transfer advances the pointer by one modulo `DEPTH`. It writes from, to and info at the new pointer. Info bit 7 is the mispredict flag, bits 6:4 the class, bits 3:2 the source privilege and bits 1:0 the target privilege.
- R3: Read position p returns the entry at physical index (pointer - p) mod `DEPTH`. After more than `DEPTH` captures, the oldest entries are overwritten.
- R4: The privilege filter looks only at the target privilege. Select bit 0 suppresses targets at level 0, and select bit 1 suppresses targets above level 0.
- R5: The class codes are conditional=0, relative call=1, indirect call=2, near return=3, indirect jump=4, relative jump=5 and far=6. A set select bit (code+2) suppresses that class. Code 7 is never recorded.
- R6: A configuration write keeps only bits 9:0 of the written word, and `sel_q` shows them.
- R7: With select bit 9 set, captured calls (codes 1, 2) push as in R2. A captured near return moves the pointer back by one and leaves the entries unchanged. Other classes change nothing.
- R8: A `pmi` pulse with select bit 9 clear sets `frozen` in the next cycle. With select bit 9 set, `pmi` has no effect. While frozen, nothing is recorded. `freeze_clr` clears the freeze, and `pmi` wins when both are high.
- R9: With `rec_en` low, offered transfers are consumed and not recorded.
- R10: `rd_valid` is high exactly one cycle after `rd_en`. The data reflect the store and the pointer as they were in the request cycle.
- R11: A software entry write or pointer write takes effect at the next edge and lowers `br_ready` in its cycle. The two writes may occur together.
- R12: `rd_empty` is high when the returned from word is zero, which marks an invalid slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| rec_en | input | 1 | Global recording enable |
| br_valid | input | 1 | Transfer offered |
| br_ready | output | 1 | Transfer accepted this cycle |
| br_from | input | ADDR_W | Source address |
| br_to | input | ADDR_W | Target address |
| br_class | input | 3 | Class code (R5) |
| br_src_priv | input | PRIV_W | Source privilege level |
| br_dst_priv | input | PRIV_W | Target privilege level |
| br_mispred | input | 1 | Transfer was mispredicted |
| cfg_we | input | 1 | Select register write strobe |
| cfg_wdata | input | 32 | Select register write data |
| sel_q | output | 10 | Current select register |
| pmi | input | 1 | Performance interrupt pulse |
| freeze_clr | input | 1 | Clear the freeze |
| frozen | output | 1 | Recording frozen |
| tos | output | IDX_W | Top-of-stack pointer |
| rd_en | input | 1 | Read request |
| rd_pos | input | IDX_W | Position back from newest |
| rd_valid | output | 1 | Read response valid |
| rd_from | output | ADDR_W | Returned source address |
| rd_to | output | ADDR_W | Returned target address |
| rd_info | output | 8 | Returned info word |
| rd_empty | output | 1 | Returned slot is invalid |
| sw_we | input | 1 | Software entry write strobe |
| sw_idx | input | IDX_W | Physical index to write |
| sw_from | input | ADDR_W | Source address to restore |
| sw_to | input | ADDR_W | Target address to restore |
| sw_info | input | 8 | Info word to restore |
| tos_we | input | 1 | Pointer write strobe |
| tos_wdata | input | IDX_W | Pointer value to restore |

## Verification
The bench drives the pointer around the ring more than once. A design that masks the index wrongly would show stale or misplaced entries at the wrap, or would read the wrong slot for positions past the wrap point. In call-stack mode it mixes calls, returns and jumps. A block that writes on returns, or records jumps, would break the stack readout. It also fires the interrupt in both modes and tries to record while frozen or disabled. A design that froze in call-stack mode, or leaked a capture through the freeze, would move the pointer where the model does not. Software writes are issued at the same time as an offered transfer, to catch a design that lets both land in one cycle.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int SEL_W      = 10;
  localparam int SEL_PRIV0  = 0;  // suppress targets at level 0
  localparam int SEL_PRIVN  = 1;  // suppress targets above level 0
  localparam int SEL_CLS0   = 2;  // first class-suppress bit
  localparam int SEL_CSTACK = 9;  // call-stack enable
  localparam int CLASS_W    = 3;

  typedef enum logic [CLASS_W-1:0] {
    BR_COND     = 3'd0,
    BR_CALL_REL = 3'd1,
    BR_CALL_IND = 3'd2,
    BR_RET_NEAR = 3'd3,
    BR_JMP_IND  = 3'd4,
    BR_JMP_REL  = 3'd5,
    BR_FAR      = 3'd6,
    BR_NONE     = 3'd7
  } br_class_e;

  function automatic logic class_is_call(input logic [CLASS_W-1:0] c);
    return (c == BR_CALL_REL) || (c == BR_CALL_IND);
  endfunction

  function automatic logic class_is_ret(input logic [CLASS_W-1:0] c);
    return c == BR_RET_NEAR;
  endfunction
endpackage

// File: rtl/lbr_filter.sv
module lbr_filter
  import lbr_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic                offer,
  input  logic [SEL_W-1:0]    sel,
  input  logic [CLASS_W-1:0]  cls,
  input  logic [PRIV_W-1:0]   dst_priv,
  output logic                push,
  output logic                pop
);
  localparam int NCLS = 1 << CLASS_W;

  logic [NCLS-1:0] cls_sup;
  logic            priv_ok;
  logic            take;

  // class code 7 (top slot) is always suppressed
  genvar gc;
  generate
    for (gc = 0; gc < NCLS; gc++) begin : g_cls
      if (gc == NCLS - 1) begin : g_none
        assign cls_sup[gc] = 1'b1;
      end else begin : g_sel
        assign cls_sup[gc] = sel[SEL_CLS0 + gc];
      end
    end
  endgenerate

  always_comb begin
    priv_ok = (dst_priv == '0) ? !sel[SEL_PRIV0] : !sel[SEL_PRIVN];
    take    = offer && priv_ok && !cls_sup[cls];
    if (sel[SEL_CSTACK]) begin
      push = take && class_is_call(cls);
      pop  = take && class_is_ret(cls);
    end else begin
      push = take;
      pop  = 1'b0;
    end
  end
endmodule

// File: rtl/lbr_ptr.sv
module lbr_ptr #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             tos_we,
  input  logic [IDX_W-1:0] tos_wdata,
  input  logic             pmi,
  input  logic             freeze_clr,
  input  logic             cs_mode,
  output logic [IDX_W-1:0] tos,
  output logic [IDX_W-1:0] wr_idx,
  output logic             frozen
);
  assign wr_idx = tos + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos <= '0;
    end else if (tos_we) begin
      tos <= tos_wdata;
    end else if (push) begin
      tos <= wr_idx;
    end else if (pop) begin
      tos <= tos - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen <= 1'b0;
    end else if (pmi && !cs_mode) begin
      frozen <= 1'b1;
    end else if (freeze_clr) begin
      frozen <= 1'b0;
    end
  end
endmodule

// File: rtl/lbr_store.sv
module lbr_store #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 48,
  parameter int INFO_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_we,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [ADDR_W-1:0] cap_from,
  input  logic [ADDR_W-1:0] cap_to,
  input  logic [INFO_W-1:0] cap_info,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [ADDR_W-1:0] sw_from,
  input  logic [ADDR_W-1:0] sw_to,
  input  logic [INFO_W-1:0] sw_info,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_from,
  output logic [ADDR_W-1:0] rd_to,
  output logic [INFO_W-1:0] rd_info
);
  logic [ADDR_W-1:0] from_arr [DEPTH];
  logic [ADDR_W-1:0] to_arr   [DEPTH];
  logic [INFO_W-1:0] info_arr [DEPTH];

  genvar ge;
  generate
    for (ge = 0; ge < DEPTH; ge++) begin : g_ent
      logic [ADDR_W-1:0] f_q, t_q;
      logic [INFO_W-1:0] i_q;
      logic              sw_hit, cap_hit;

      assign sw_hit  = sw_we  && (sw_idx  == IDX_W'(ge));
      assign cap_hit = cap_we && (cap_idx == IDX_W'(ge));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          f_q <= '0;
          t_q <= '0;
          i_q <= '0;
        end else if (sw_hit) begin
          f_q <= sw_from;
          t_q <= sw_to;
          i_q <= sw_info;
        end else if (cap_hit) begin
          f_q <= cap_from;
          t_q <= cap_to;
          i_q <= cap_info;
        end
      end

      assign from_arr[ge] = f_q;
      assign to_arr[ge]   = t_q;
      assign info_arr[ge] = i_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_from  <= '0;
      rd_to    <= '0;
      rd_info  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_from <= from_arr[rd_idx];
        rd_to   <= to_arr[rd_idx];
        rd_info <= info_arr[rd_idx];
      end
    end
  end
endmodule

// File: rtl/lbr_ring.sv
module lbr_ring
  import lbr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 48,
  parameter int PRIV_W = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int INFO_W = 1 + CLASS_W + 2 * PRIV_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rec_en,
  input  logic               br_valid,
  output logic               br_ready,
  input  logic [ADDR_W-1:0]  br_from,
  input  logic [ADDR_W-1:0]  br_to,
  input  logic [CLASS_W-1:0] br_class,
  input  logic [PRIV_W-1:0]  br_src_priv,
  input  logic [PRIV_W-1:0]  br_dst_priv,
  input  logic               br_mispred,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  output logic [SEL_W-1:0]   sel_q,
  input  logic               pmi,
  input  logic               freeze_clr,
  output logic               frozen,
  output logic [IDX_W-1:0]   tos,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_pos,
  output logic               rd_valid,
  output logic [ADDR_W-1:0]  rd_from,
  output logic [ADDR_W-1:0]  rd_to,
  output logic [INFO_W-1:0]  rd_info,
  output logic               rd_empty,
  input  logic               sw_we,
  input  logic [IDX_W-1:0]   sw_idx,
  input  logic [ADDR_W-1:0]  sw_from,
  input  logic [ADDR_W-1:0]  sw_to,
  input  logic [INFO_W-1:0]  sw_info,
  input  logic               tos_we,
  input  logic [IDX_W-1:0]   tos_wdata
);
  logic              offer;
  logic              cap_push, cap_pop;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [INFO_W-1:0] cap_info;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (cfg_we) sel_q <= cfg_wdata[SEL_W-1:0];
  end

  assign br_ready = !(sw_we || tos_we);
  assign offer    = br_valid && br_ready && rec_en && !frozen;
  assign cap_info = {br_mispred, br_class, br_src_priv, br_dst_priv};
  assign rd_idx   = tos - rd_pos;
  assign rd_empty = (rd_from == '0);

  lbr_filter #(.PRIV_W(PRIV_W)) u_filter (
    .offer    (offer),
    .sel      (sel_q),
    .cls      (br_class),
    .dst_priv (br_dst_priv),
    .push     (cap_push),
    .pop      (cap_pop)
  );

  lbr_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (cap_push),
    .pop        (cap_pop),
    .tos_we     (tos_we),
    .tos_wdata  (tos_wdata),
    .pmi        (pmi),
    .freeze_clr (freeze_clr),
    .cs_mode    (sel_q[SEL_CSTACK]),
    .tos        (tos),
    .wr_idx     (wr_idx),
    .frozen     (frozen)
  );

  lbr_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .INFO_W(INFO_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_we   (cap_push),
    .cap_idx  (wr_idx),
    .cap_from (br_from),
    .cap_to   (br_to),
    .cap_info (cap_info),
    .sw_we    (sw_we),
    .sw_idx   (sw_idx),
    .sw_from  (sw_from),
    .sw_to    (sw_to),
    .sw_info  (sw_info),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .rd_from  (rd_from),
    .rd_to    (rd_to),
    .rd_info  (rd_info)
  );
endmodule

// File: rtl/lbr_ring_chk.sv
module lbr_ring_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push,
  input logic             pop,
  input logic [IDX_W-1:0] tos,
  input logic             frozen,
  input logic             cs_mode,
  input logic             pmi,
  input logic             sw_we,
  input logic             tos_we,
  input logic             rd_en,
  input logic             rd_valid
);
  // R2
  push_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> tos == IDX_W'($past(tos) + 1'b1));

  // R7
  pop_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> tos == IDX_W'($past(tos) - 1'b1));

  // R7
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

  // R8
  freeze_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pmi && !cs_mode) |=> frozen);

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !tos_we) |=> $stable(tos));

  // R8
  cs_no_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && cs_mode) |=> !frozen);

  // R11
  sw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we || tos_we) |-> !(push || pop));

  // R10
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind lbr_ring lbr_ring_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .push     (cap_push),
  .pop      (cap_pop),
  .tos      (tos),
  .frozen   (frozen),
  .cs_mode  (sel_q[9]),
  .pmi      (pmi),
  .sw_we    (sw_we),
  .tos_we   (tos_we),
  .rd_en    (rd_en),
  .rd_valid (rd_valid)
);

// File: tb/tb_lbr_ring.sv
`timescale 1ns/1ps
module tb_lbr_ring;
  localparam int DEPTH = 16;
  localparam int AW    = 48;
  localparam int IW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          rec_en = 0, br_valid = 0, br_mispred = 0;
  logic          br_ready;
  logic [AW-1:0] br_from = '0, br_to = '0;
  logic [2:0]    br_class = '0;
  logic [1:0]    br_src_priv = '0, br_dst_priv = '0;
  logic          cfg_we = 0;
  logic [31:0]   cfg_wdata = '0;
  logic [9:0]    sel_q;
  logic          pmi = 0, freeze_clr = 0, frozen;
  logic [IW-1:0] tos;
  logic          rd_en = 0, rd_valid, rd_empty;
  logic [IW-1:0] rd_pos = '0;
  logic [AW-1:0] rd_from, rd_to;
  logic [7:0]    rd_info;
  logic          sw_we = 0, tos_we = 0;
  logic [IW-1:0] sw_idx = '0, tos_wdata = '0;
  logic [AW-1:0] sw_from = '0, sw_to = '0;
  logic [7:0]    sw_info = '0;

  lbr_ring #(.DEPTH(DEPTH), .ADDR_W(AW), .PRIV_W(2)) dut (.*);

  // behavioural reference model
  logic [AW-1:0] mf [DEPTH];
  logic [AW-1:0] mt [DEPTH];
  logic [7:0]    mi [DEPTH];
  int            mtos = 0;
  bit            mfrozen = 0;
  logic [9:0]    msel = '0;

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit push = 0, pop = 0, sup;
    int c;
    if (sw_we || tos_we) begin
      if (sw_we) begin
        mf[sw_idx] = sw_from; mt[sw_idx] = sw_to; mi[sw_idx] = sw_info;
      end
      if (tos_we) mtos = int'(tos_wdata);
    end else if (br_valid && rec_en && !mfrozen) begin
      c = int'(br_class);
      sup = (br_dst_priv == 0) ? msel[0] : msel[1];
      if (c == 7) sup = 1;
      else if (msel[2 + c]) sup = 1;
      if (!sup) begin
        if (msel[9]) begin
          if (c == 1 || c == 2) push = 1;
          else if (c == 3) pop = 1;
        end else push = 1;
      end
      if (push) begin
        mtos = (mtos + 1) % DEPTH;
        mf[mtos] = br_from; mt[mtos] = br_to;
        mi[mtos] = {br_mispred, br_class, br_src_priv, br_dst_priv};
      end
      if (pop) mtos = (mtos + DEPTH - 1) % DEPTH;
    end
    if (pmi && !msel[9]) mfrozen = 1;
    else if (freeze_clr) mfrozen = 0;
    if (cfg_we) msel = cfg_wdata[9:0];
  endtask

  // one clock: inputs already driven; compare after the edge
  task automatic cyc(input string tag);
    bit            erv;
    int            idx;
    logic [AW-1:0] ef, et;
    logic [7:0]    ei;
    #1;
    chk(br_ready == !(sw_we || tos_we), "R11", "br_ready", 64'(br_ready), 64'(!(sw_we || tos_we)));
    erv = rd_en;
    idx = (mtos - int'(rd_pos) + DEPTH) % DEPTH;
    ef = mf[idx]; et = mt[idx]; ei = mi[idx];
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tos == IW'(mtos), tag, "tos", 64'(tos), 64'(mtos));
    chk(frozen == mfrozen, "R8", "frozen", 64'(frozen), 64'(mfrozen));
    chk(sel_q == msel, "R6", "sel_q", 64'(sel_q), 64'(msel));
    chk(rd_valid == erv, "R10", "rd_valid", 64'(rd_valid), 64'(erv));
    if (erv) begin
      chk(rd_from == ef, tag, "rd_from", 64'(rd_from), 64'(ef));
      chk(rd_to == et, tag, "rd_to", 64'(rd_to), 64'(et));
      chk(rd_info == ei, tag, "rd_info", 64'(rd_info), 64'(ei));
      chk(rd_empty == (ef == 0), "R12", "rd_empty", 64'(rd_empty), 64'(ef == 0));
    end
    br_valid = 0; cfg_we = 0; pmi = 0; freeze_clr = 0;
    rd_en = 0; sw_we = 0; tos_we = 0;
  endtask

  task automatic br(input logic [AW-1:0] f, input logic [AW-1:0] t, input int c,
                    input int s, input int d, input bit m, input string tag);
    br_valid = 1; br_from = f; br_to = t; br_class = 3'(c);
    br_src_priv = 2'(s); br_dst_priv = 2'(d); br_mispred = m;
    cyc(tag);
  endtask

  task automatic cfg(input logic [31:0] v, input string tag);
    cfg_we = 1; cfg_wdata = v; cyc(tag);
  endtask

  task automatic rd(input int p, input string tag);
    rd_en = 1; rd_pos = IW'(p); cyc(tag);
  endtask

  task automatic rdall(input int n, input string tag);
    for (int p = 0; p < n; p++) rd(p, tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mf[i] = '0; mt[i] = '0; mi[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(tos == 0, "R1", "tos after reset", 64'(tos), 0);
    chk(frozen == 0, "R1", "frozen after reset", 64'(frozen), 0);
    chk(sel_q == 0, "R1", "sel after reset", 64'(sel_q), 0);
    rdall(DEPTH, "R1");

    // R9: disabled
    br(48'h1000, 48'h2000, 0, 3, 3, 0, "R9");
    rec_en = 1;

    // R2 / R3: plain capture with varied classes and privileges
    for (int k = 0; k < 5; k++)
      br(48'h4000 + 48'(k * 16), 48'h8000 + 48'(k * 32), k, k % 4, (k + 1) % 4, k[0], "R2");
    rdall(6, "R3");
    // R3: wrap beyond depth
    for (int k = 0; k < 20; k++)
      br(48'hA00000 + 48'(k), 48'hB00000 + 48'(k), k % 7, 0, 3, 0, "R3");
    rdall(DEPTH, "R3");

    // R4: target privilege filter
    cfg(32'h1, "R4");
    br(48'h111, 48'h222, 0, 3, 0, 0, "R4");
    br(48'h333, 48'h444, 0, 0, 2, 0, "R4");
    cfg(32'h2, "R4");
    br(48'h555, 48'h666, 0, 0, 1, 0, "R4");
    br(48'h777, 48'h888, 0, 3, 0, 1, "R4");
    rdall(3, "R4");

    // R5: class suppress bits and code 7
    for (int c = 0; c < 7; c++) begin
      cfg(32'(1 << (c + 2)), "R5");
      br(48'hC000 + 48'(c), 48'hD000, c, 0, 0, 0, "R5");
      br(48'hE000 + 48'(c), 48'hF000, (c + 1) % 7, 0, 0, 0, "R5");
    end
    cfg(32'h0, "R5");
    br(48'h9999, 48'h9998, 7, 0, 0, 0, "R5");
    rdall(4, "R5");

    // R6: upper bits dropped
    cfg(32'hFFFF_FC00, "R6");
    cfg(32'hABCD_E0F3, "R6");
    cfg(32'h0, "R6");

    // R7: call-stack mode
    cfg(32'h200, "R7");
    br(48'h10, 48'h20, 1, 3, 3, 0, "R7");
    br(48'h30, 48'h40, 2, 3, 3, 0, "R7");
    br(48'h50, 48'h60, 4, 3, 3, 0, "R7");
    br(48'h70, 48'h80, 0, 3, 3, 0, "R7");
    br(48'h90, 48'hA0, 1, 3, 3, 0, "R7");
    br(48'hB0, 48'hC0, 3, 3, 3, 0, "R7");
    br(48'hD0, 48'hE0, 3, 3, 3, 0, "R7");
    rdall(3, "R7");
    // R8: pmi ignored in call-stack mode
    pmi = 1; cyc("R8");
    br(48'hF0, 48'hF8, 2, 0, 0, 0, "R8");

    // R8: freeze outside call-stack mode
    cfg(32'h0, "R8");
    pmi = 1; br(48'h1234, 48'h5678, 0, 0, 0, 0, "R8");
    br(48'h2345, 48'h6789, 0, 0, 0, 0, "R8");
    pmi = 1; freeze_clr = 1; cyc("R8");
    br(48'h3456, 48'h789A, 5, 0, 0, 0, "R8");
    freeze_clr = 1; cyc("R8");
    br(48'h4567, 48'h89AB, 6, 1, 1, 1, "R8");
    rdall(3, "R8");

    // R11: software writes block intake
    sw_we = 1; sw_idx = 4'd5; sw_from = 48'hFACE; sw_to = 48'hBEEF; sw_info = 8'h5A;
    tos_we = 1; tos_wdata = 4'd5;
    br(48'hDEAD, 48'hDEAD, 0, 0, 0, 0, "R11");
    rdall(2, "R11");
    sw_we = 1; sw_idx = 4'd6; sw_from = 48'h0; sw_to = 48'h0; sw_info = 8'h0;
    cyc("R11");
    tos_we = 1; tos_wdata = 4'd6; cyc("R11");
    rd(0, "R12");
    br(48'h5151, 48'h5252, 1, 2, 2, 0, "R2");
    rdall(2, "R3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule